// File: doc/BRIEF.md
# Transmit Nibble Symbol Assembler

This block sits at the entry of a transmit data path. It takes a narrow 6-bit bus, sampled on every rising edge of the master clock, and rebuilds complex transmit symbols. Each symbol has a 12-bit in-phase word and a 12-bit quadrature word, so four nibbles make one 24-bit symbol. A framing input marks the first nibble of a symbol. Each complete symbol goes to the interpolation stage that follows, together with a single-cycle valid strobe.

Once the sync input has framed it, the assembler keeps counting nibbles in groups of four, so back-to-back symbols need no further sync. A new sync at any position restarts the framing and drops the partial symbol. A tone-only mode turns the assembler off entirely. In that mode the bus is ignored, the outputs are driven to zero, no strobes are produced, and framing is lost until the next sync.

Top module: `txnib_assembler`

## Requirements
- R1: While reset is low and in the cycle after it is released, `sym_i` and `sym_q` are zero and `sym_valid` is low.
- R2: A cycle with `nib_sync` high carries the first nibble of a symbol. The four nibbles form I[11:6], I[5:0], Q[11:6] and Q[5:0], in that order. The symbol appears on `sym_i`/`sym_q` with `sym_valid` high for exactly one cycle, in the cycle after the fourth nibble.
- R3: After a complete symbol, the next four nibbles form the next symbol without any sync, so a continuous stream yields one valid symbol every four cycles.
- R4: After reset and before the first sync, nibbles are ignored and no valid strobe is produced.
- R5: A sync on the second, third or fourth nibble of a symbol discards the partial symbol. The sync nibble becomes I[11:6] of a new symbol, and no valid strobe follows the sync cycle.
- R6: While `tone_mode` is high, the bus and sync are ignored. In the following cycle the outputs are zero and `sym_valid` is low. After `tone_mode` falls, no symbol is produced until a new sync.
- R7: Between valid strobes, `sym_i` and `sym_q` hold the last assembled symbol, unless tone mode clears them.
- R8: If `tone_mode` is high during any nibble of a symbol, that symbol is never emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; nibbles sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tone_mode | input | 1 | High selects tone-only operation; the bus is ignored |
| nib_in | input | 6 | Nibble bus |
| nib_sync | input | 1 | High marks the first nibble of a symbol |
| sym_i | output | 12 | Assembled in-phase word |
| sym_q | output | 12 | Assembled quadrature word |
| sym_valid | output | 1 | One-cycle strobe for a new symbol |

## Verification
The assertions assume that the symbol length is at least two nibbles. They also assume that `tone_mode` and `nib_sync` are stable for the whole cycle around each rising edge, so every sampled value is a clean level. The stimulus changes all inputs only on the falling clock edge. It sweeps sync offsets and tone-mode entry points across all four nibble positions, which keeps the assertions' view of a symbol boundary consistent with the inputs.

// File: rtl/txnib_pkg.sv
// Shared defaults and types for the transmit nibble assembler.
// Assumes: a symbol is two equal words whose total width is a multiple of the nibble width.
package txnib_pkg;
    localparam int NIB_W_DEF  = 6;
    localparam int WORD_W_DEF = 12;

    // Framing state: hunting for a sync, or locked to a nibble count.
    typedef enum logic {
        FR_HUNT = 1'b0,
        FR_LOCK = 1'b1
    } frame_state_t;
endpackage

// File: rtl/txnib_framer.sv
// Nibble framer: tracks which slot of the symbol the current nibble fills.
// Assumes: NIBS >= 2; sync restarts at slot 0; tone mode drops lock.
module txnib_framer
    import txnib_pkg::*;
#(
    parameter int NIBS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync,
    input  logic            tone,
    output logic [NIBS-2:0] wr_en,
    output logic            last
);
    localparam int IDX_W = $clog2(NIBS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIBS - 1);

    frame_state_t   state;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] cur_slot;
    logic             active;

    // Current slot and whether this nibble is accepted.
    always_comb begin
        cur_slot = sync ? '0 : idx;
        active   = !tone && (sync || state == FR_LOCK);
        last     = active && (cur_slot == LAST_IDX);
    end

    // One write enable per held slot (the final slot goes straight out).
    genvar k;
    generate
        for (k = 0; k < NIBS - 1; k++) begin : g_we
            assign wr_en[k] = active && (cur_slot == IDX_W'(k));
        end
    endgenerate

    // Advance the slot counter and the lock state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FR_HUNT;
            idx   <= '0;
        end else if (tone) begin
            state <= FR_HUNT;
            idx   <= '0;
        end else if (active) begin
            state <= FR_LOCK;
            idx   <= (cur_slot == LAST_IDX) ? '0 : cur_slot + 1'b1;
        end
    end
endmodule

// File: rtl/txnib_capture.sv
// Nibble capture: holds the leading nibbles of a symbol and forms the full word.
// Assumes: slot 0 is the most significant nibble; the last nibble is taken live.
module txnib_capture #(
    parameter int NIB_W = 6,
    parameter int NIBS  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NIBS-2:0]       wr_en,
    input  logic [NIB_W-1:0]      nib,
    output logic [NIB_W*NIBS-1:0] assembled
);
    genvar k;
    generate
        for (k = 0; k < NIBS - 1; k++) begin : g_slot
            logic [NIB_W-1:0] hold;
            // Store this slot's nibble when it arrives.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hold <= '0;
                else if (wr_en[k])
                    hold <= nib;
            end
            assign assembled[NIB_W*(NIBS-1-k) +: NIB_W] = hold;
        end
    endgenerate

    // Final slot comes directly from the bus.
    assign assembled[NIB_W-1:0] = nib;
endmodule

// File: rtl/txnib_outreg.sv
// Output stage: registers a finished symbol and its strobe; clears in tone mode.
// Assumes: load is high only in the cycle of a symbol's final nibble.
module txnib_outreg #(
    parameter int SYM_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tone,
    input  logic             load,
    input  logic [SYM_W-1:0] din,
    output logic [SYM_W-1:0] dout,
    output logic             valid
);
    // Load, hold or clear the symbol register and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || tone) begin
            dout  <= '0;
            valid <= 1'b0;
        end else if (load) begin
            dout  <= din;
            valid <= 1'b1;
        end else begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/txnib_assembler.sv
// Top: builds I/Q symbols from a nibble bus under sync framing, with tone bypass.
// Assumes: inputs synchronous to clk; symbol = 2*WORD_W bits, I in the upper half.
module txnib_assembler
    import txnib_pkg::*;
#(
    parameter int NIB_W  = NIB_W_DEF,
    parameter int WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tone_mode,
    input  logic [NIB_W-1:0]  nib_in,
    input  logic              nib_sync,
    output logic [WORD_W-1:0] sym_i,
    output logic [WORD_W-1:0] sym_q,
    output logic              sym_valid
);
    localparam int SYM_W = 2 * WORD_W;
    localparam int NIBS  = SYM_W / NIB_W;

    logic [NIBS-2:0]  wr_en;
    logic             last;
    logic [SYM_W-1:0] assembled;
    logic [SYM_W-1:0] sym_q_full;

    txnib_framer #(.NIBS(NIBS)) u_framer (
        .clk   (clk),
        .rst_n (rst_n),
        .sync  (nib_sync),
        .tone  (tone_mode),
        .wr_en (wr_en),
        .last  (last)
    );

    txnib_capture #(.NIB_W(NIB_W), .NIBS(NIBS)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .nib       (nib_in),
        .assembled (assembled)
    );

    txnib_outreg #(.SYM_W(SYM_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .tone  (tone_mode),
        .load  (last),
        .din   (assembled),
        .dout  (sym_q_full),
        .valid (sym_valid)
    );

    assign sym_i = sym_q_full[SYM_W-1:WORD_W];
    assign sym_q = sym_q_full[WORD_W-1:0];
endmodule

// File: rtl/txnib_checker.sv
// Checker: port-level temporal properties of the nibble assembler.
// Assumes: symbols are at least two nibbles long.
module txnib_checker #(
    parameter int WORD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tone_mode,
    input logic              nib_sync,
    input logic [WORD_W-1:0] sym_i,
    input logic [WORD_W-1:0] sym_q,
    input logic              sym_valid
);
    // The strobe never lasts two cycles.
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> !sym_valid);

    // A sync cycle starts a symbol, so no strobe follows it.
    assert_sync_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_sync && !tone_mode) |=> !sym_valid);

    // Tone mode suppresses strobes.
    assert_tone_nostrobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tone_mode |=> !sym_valid);

    // Tone mode zeroes the outputs.
    assert_tone_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tone_mode |=> (sym_i == '0 && sym_q == '0));

    // Without a strobe or tone, the outputs hold.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tone_mode |=> (sym_valid || ($stable(sym_i) && $stable(sym_q))));
endmodule

bind txnib_assembler txnib_checker #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tone_mode (tone_mode),
    .nib_sync  (nib_sync),
    .sym_i     (sym_i),
    .sym_q     (sym_q),
    .sym_valid (sym_valid)
);

// File: tb/sim_txnib_assembler.sv
// Bench: sweeps symbol values, sync offsets and tone entry points.
module sim_txnib_assembler;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tone_mode = 1'b0;
    logic [5:0]  nib_in = '0;
    logic        nib_sync = 1'b0;
    logic [11:0] sym_i, sym_q;
    logic        sym_valid;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [11:0] prev_i = '0, prev_q = '0;

    txnib_assembler u0 (
        .clk(clk), .rst_n(rst_n), .tone_mode(tone_mode), .nib_in(nib_in),
        .nib_sync(nib_sync), .sym_i(sym_i), .sym_q(sym_q), .sym_valid(sym_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run is counted as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WD_LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Apply inputs for one cycle; return at the next falling edge.
    task automatic drive(input bit s, input bit t, input logic [5:0] n);
        nib_sync  = s;
        tone_mode = t;
        nib_in    = n;
        @(negedge clk);
    endtask

    // Send one symbol; check the hold between strobes and the result.
    task automatic send_sym(input logic [11:0] iv, input logic [11:0] qv,
                            input bit use_sync, input string req);
        logic [5:0] nibs [4];
        nibs[0] = iv[11:6]; nibs[1] = iv[5:0]; nibs[2] = qv[11:6]; nibs[3] = qv[5:0];
        for (int k = 0; k < 4; k++) begin
            drive(k == 0 && use_sync, 1'b0, nibs[k]);
            if (k < 3) begin
                chk(!sym_valid, "R7 no strobe mid-symbol", sym_valid, 0);
                chk(sym_i == prev_i && sym_q == prev_q, "R7 hold",
                    {sym_i, sym_q}, {prev_i, prev_q});
            end else begin
                chk(sym_valid, req, sym_valid, 1);
                chk(sym_i == iv && sym_q == qv, req, {sym_i, sym_q}, {iv, qv});
            end
        end
        prev_i = iv;
        prev_q = qv;
    endtask

    initial begin
        @(negedge clk);
        chk(sym_i == 0 && sym_q == 0 && !sym_valid, "R1 in reset", {sym_i, sym_q, sym_valid}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sym_i == 0 && sym_q == 0 && !sym_valid, "R1 after reset", {sym_i, sym_q, sym_valid}, 0);

        // R4: unframed nibbles give nothing.
        for (int k = 0; k < 12; k++) begin
            drive(1'b0, 1'b0, 6'(k * 5 + 3));
            chk(!sym_valid && sym_i == 0, "R4 unframed", {sym_i, sym_valid}, 0);
        end

        // R2: synced symbols over a value sweep, plus corners.
        send_sym(12'h000, 12'hFFF, 1'b1, "R2 corner");
        send_sym(12'hFFF, 12'h000, 1'b1, "R2 corner");
        for (int k = 0; k < 96; k++)
            send_sym(12'((k * 397 + 11) % 4096), 12'((k * 1013 + 7) % 4096), 1'b1, "R2 sweep");

        // R3: back-to-back stream with no further sync.
        send_sym(12'h5A5, 12'hA5A, 1'b1, "R3 first");
        for (int k = 0; k < 64; k++)
            send_sym(12'((k * 211 + 99) % 4096), 12'((k * 37 + 1500) % 4096), 1'b0, "R3 unsynced");

        // R5: sync after 1, 2 or 3 nibbles restarts the symbol.
        for (int off = 1; off < 4; off++) begin
            drive(1'b1, 1'b0, 6'h3F);
            chk(!sym_valid, "R5 sync no strobe", sym_valid, 0);
            for (int k = 1; k < off; k++) begin
                drive(1'b0, 1'b0, 6'h2A);
                chk(!sym_valid, "R5 partial", sym_valid, 0);
            end
            send_sym(12'(off * 1111), 12'(off * 555 + 9), 1'b1, "R5 restart");
        end

        // R6: tone mode zeroes outputs and ignores the bus and sync.
        for (int k = 0; k < 10; k++) begin
            drive(k[0], 1'b1, 6'(k * 7));
            chk(!sym_valid && sym_i == 0 && sym_q == 0, "R6 tone zero",
                {sym_i, sym_q, sym_valid}, 0);
        end
        prev_i = '0; prev_q = '0;
        for (int k = 0; k < 8; k++) begin
            drive(1'b0, 1'b0, 6'(k + 20));
            chk(!sym_valid && sym_i == 0, "R6 lock lost", {sym_i, sym_valid}, 0);
        end
        send_sym(12'h123, 12'h456, 1'b1, "R6 resync");

        // R8: tone at each nibble position kills that symbol.
        for (int p = 0; p < 4; p++) begin
            send_sym(12'(p * 300 + 1), 12'(p * 300 + 2), 1'b1, "R8 pre");
            for (int k = 0; k < 4; k++) begin
                drive(k == 0, k == p, 6'h15);
                if (k >= p)
                    chk(!sym_valid && sym_i == 0 && sym_q == 0, "R8 symbol dropped",
                        {sym_i, sym_q, sym_valid}, 0);
                else
                    chk(!sym_valid, "R8 before tone", sym_valid, 0);
            end
            prev_i = '0; prev_q = '0;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule